// File: doc/BRIEF.md
# Multi-Mode Asynchronous Serial Channel

This block is one full-duplex asynchronous serial channel for a small embedded controller. Software reaches it through a register port with three addresses. The data address is shared between the two directions. A write to it loads the transmitter and starts a frame at once. A read from it returns the last byte the receiver captured. The control register selects the frame shape and the number of stop bits, and enables the receiver. It also holds the ninth bit in each direction and two sticky event flags. An auxiliary register selects the fixed-rate divisor and holds a framing-error flag.

A frame can carry 8 data bits, or 8 data bits followed by a ninth bit. Software supplies the ninth bit on transmit and reads it back on receive, so it can serve as parity or as an address marker. Bit timing normally comes from a 16x oversampling tick that a separate rate generator supplies. One of the 9-bit modes ignores that tick and derives a fixed rate from the system clock instead. The transmitter and the receiver run independently and can both be active in the same cycles.

Top module: `sio_port`

## Requirements
- R1: The transmit line idles high. A frame is a low start bit, then 8 data bits least-significant first, then a high stop bit. In the 8-bit modes (mode field 2'b00 or 2'b01) no ninth bit is sent.
- R2: In the 9-bit modes (mode field 2'b10 or 2'b11), the value of control bit 3 is sent as a ninth bit between the last data bit and the stop bit.
- R3: The receiver assembles a frame least-significant bit first. It sets the receive-ready flag (control bit 0) and makes the byte readable at address 0. It stores the ninth received bit in control bit 2. In 8-bit modes, control bit 2 takes the level sampled for the stop bit instead.
- R4: Address 0 is shared between the two directions. A write to it starts a transmission, and a read from it returns the last received byte, which a write never changes. Address 1 is the control register and address 2 is the auxiliary register.
- R5: When control bit 5 is set, the transmitter sends two stop bits. The transmit-done flag (control bit 1) sets only after the last stop bit has ended.
- R6: In mode 2'b10, each bit lasts 32 clock cycles when auxiliary bit 0 is 0, and 64 clock cycles when it is 1, whatever the tick input does. In the other modes each bit lasts 16 pulses of the tick input.
- R7: A falling edge that is high again when the receiver samples at mid-bit (the 8th tick) is rejected. It delivers no byte and sets no flag.
- R8: Control layout: [7:6] mode, [5] two stop bits, [4] receive enable, [3] transmit ninth bit, [2] received ninth bit (read-only), [1] transmit done, [0] receive ready. The two flags stay set until software writes 0 to them. Writing 1 to a flag leaves it unchanged.
- R9: If the stop bit is sampled low, auxiliary bit 1 (the framing-error flag) sets, and it is cleared by writing 0. The byte is still delivered. The receiver then waits for the line to go high before it looks for a new start bit.
- R10: A write to address 0 while a frame is being sent is ignored. The current frame is not disturbed, and no second frame follows it.
- R11: A transmit frame and a receive frame in progress at the same time both complete correctly.
- R12: When receive enable (control bit 4) is 0, activity on the receive line delivers nothing and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16_i | input | 1 | Oversampling tick from the rate generator, 16 per bit |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 auxiliary |
| bus_wdata | input | DW (8) | Register write data |
| bus_rdata | output | DW (8) | Register read data for bus_addr |
| rxd | input | 1 | Serial receive line, asynchronous |
| txd | output | 1 | Serial transmit line |

## Verification
The hardest situation to reach is a receive frame whose stop bit is low. The receiver must deliver the byte, raise the error, and then wait for the line to recover rather than mistake the still-low line for a new start. The bench drives such a frame and follows it directly with a good frame, which must arrive intact. It also creates a transmitter that is busy when a second write lands, by writing the data address from a parallel thread three bit times into a frame. It reaches fixed-rate operation with the tick input silenced, so any dependence on the tick stalls the frame. Random frames in every mode run transmit and receive at the same moment.

// File: rtl/sio_pkg.sv
// Shared types for the serial channel: mode encoding, receiver states and helpers.
package sio_pkg;

    typedef enum logic [1:0] {
        MODE_BYTE_ALT = 2'b00,   // 8-bit frame, tick-driven rate
        MODE_BYTE     = 2'b01,   // 8-bit frame, tick-driven rate
        MODE_NINE_FIX = 2'b10,   // 9-bit frame, fixed clock-derived rate
        MODE_NINE_VAR = 2'b11    // 9-bit frame, tick-driven rate
    } sio_mode_e;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'b00,
        RX_START = 2'b01,
        RX_BITS  = 2'b10,
        RX_STOP  = 2'b11
    } rx_state_e;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_AUX  = 2'd2;

    // True when the mode carries a ninth bit.
    function automatic logic mode_has_ninth(input logic [1:0] m);
        return m[1];
    endfunction

    // True when the mode uses the fixed clock-derived rate.
    function automatic logic mode_is_fixed(input logic [1:0] m);
        return m == MODE_NINE_FIX;
    endfunction

endpackage

// File: rtl/sio_tick_sel.sv
// Bit-rate tick selection.
// Produces the oversampling tick used by both shifters. In fixed-rate mode a
// free-running prescaler divides the clock so that OVS ticks span 32 or 64
// clocks. Otherwise the external tick passes through unchanged.
// Assumes OVS divides 32 and the external tick is a one-cycle pulse.
module sio_tick_sel #(
    parameter int OVS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_ext,
    input  logic fixed_en,
    input  logic div64,
    output logic tick
);
    localparam int PER32 = 32 / OVS;
    localparam int PER64 = 64 / OVS;
    localparam int CW    = $clog2(PER64) + 1;

    logic [CW-1:0] pre_q;
    logic [CW-1:0] per_last;
    logic          pre_hit;

    assign per_last = div64 ? CW'(PER64 - 1) : CW'(PER32 - 1);
    assign pre_hit  = pre_q >= per_last;

    // Free-running prescaler that wraps on each fixed-rate tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_q <= '0;
        else if (pre_hit) pre_q <= '0;
        else              pre_q <= pre_q + 1'b1;
    end

    assign tick = fixed_en ? pre_hit : tick_ext;

    a_r6_fixed_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_en && tick) |=> !(fixed_en && tick));

endmodule

// File: rtl/sio_tx.sv
// Transmit shifter.
// On start while idle it loads a whole frame into a shift register:
// start, data LSB first, optional ninth bit, then one or two stop bits.
// It moves one bit out every OVS ticks. A start request while busy is dropped.
// done pulses for one cycle when the last stop bit ends.
module sio_tx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  logic          ninth_en,
    input  logic          ninth,
    input  logic          stop2,
    output logic          txd,
    output logic          busy,
    output logic          done
);
    localparam int FW = DW + 4;
    localparam int CW = $clog2(OVS);
    localparam int NW = $clog2(FW + 1);

    logic [FW-1:0] sh_q;
    logic [FW-1:0] frame;
    logic [NW-1:0] left_q;
    logic [NW-1:0] nbits;
    logic [CW-1:0] tcnt_q;

    // Assemble the frame image and its bit count.
    always_comb begin
        frame        = '1;
        frame[0]     = 1'b0;
        frame[DW:1]  = data;
        if (ninth_en) frame[DW+1] = ninth;
        nbits = NW'(DW + 2) + NW'(ninth_en) + NW'(stop2);
    end

    // Frame loading, bit pacing and end-of-frame signalling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '1;
            left_q <= '0;
            tcnt_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                sh_q   <= frame;
                left_q <= nbits;
                tcnt_q <= '0;
                busy   <= 1'b1;
            end else if (busy && tick) begin
                if (tcnt_q == CW'(OVS - 1)) begin
                    tcnt_q <= '0;
                    sh_q   <= {1'b1, sh_q[FW-1:1]};
                    left_q <= left_q - 1'b1;
                    if (left_q == NW'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    tcnt_q <= tcnt_q + 1'b1;
                end
            end
        end
    end

    assign txd = sh_q[0];

    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    a_r5_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    a_r10_busy_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !tick) |=> $stable(sh_q));

endmodule

// File: rtl/sio_rx.sv
// Receive shifter.
// Synchronises the line, then waits for it to be high (armed). On the first
// low tick it counts to mid-bit and confirms the start. After that it samples
// each data bit, the optional ninth bit and the stop bit every OVS ticks.
// valid pulses with the captured word. A low stop bit is reported as ferr.
// Assumes tick is a one-cycle pulse at OVS times the bit rate.
module sio_rx #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          enable,
    input  logic          ninth_en,
    output logic          valid_o,
    output logic [DW-1:0] word_o,
    output logic          ninth_o,
    output logic          ferr_o
);
    import sio_pkg::*;

    localparam int CW = $clog2(OVS);
    localparam int IW = $clog2(DW + 1);

    logic [1:0]    sync_q;
    logic          rxs;
    logic          armed_q;
    logic          nine_q;
    rx_state_e     state_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic [DW:0]   sh_q;
    logic [IW-1:0] last_idx;

    assign rxs      = sync_q[1];
    assign last_idx = nine_q ? IW'(DW) : IW'(DW - 1);

    // Two-flop synchroniser on the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Frame state machine, bit sampling and word delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            armed_q <= 1'b0;
            nine_q  <= 1'b0;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            valid_o <= 1'b0;
            word_o  <= '0;
            ninth_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (rxs) armed_q <= 1'b1;
                    if (enable && tick && armed_q && !rxs) begin
                        state_q <= RX_START;
                        armed_q <= 1'b0;
                        nine_q  <= ninth_en;
                        cnt_q   <= '0;
                    end
                end
                RX_START: if (tick) begin
                    if (cnt_q == CW'(OVS / 2 - 1)) begin
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        state_q <= rxs ? RX_IDLE : RX_BITS;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_BITS: if (tick) begin
                    if (cnt_q == CW'(OVS - 1)) begin
                        cnt_q <= '0;
                        sh_q  <= {rxs, sh_q[DW:1]};
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == last_idx) state_q <= RX_STOP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                RX_STOP: if (tick) begin
                    if (cnt_q == CW'(OVS - 1)) begin
                        cnt_q   <= '0;
                        valid_o <= 1'b1;
                        word_o  <= nine_q ? sh_q[DW-1:0] : sh_q[DW:1];
                        ninth_o <= nine_q ? sh_q[DW] : rxs;
                        ferr_o  <= !rxs;
                        state_q <= RX_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

    a_r3_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(state_q) == RX_STOP));
    a_r9_rearm_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == RX_IDLE && state_q == RX_START) |-> $past(armed_q));

endmodule

// File: rtl/sio_port.sv
// Serial channel top: register file plus the tick selector and both shifters.
// Address 0 is shared: a write starts transmission, a read returns the last
// received byte. Address 1 is the control register and address 2 the auxiliary
// register. Event flags are sticky; hardware setting wins over a software clear.
// Assumes DW >= 8. The control and auxiliary fields sit in the low 8 bits.
module sio_port #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16_i,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          rxd,
    output logic          txd
);
    import sio_pkg::*;

    logic [1:0]    mode_q;
    logic          stop2_q, rxen_q, tx9_q, rx9_q, txdone_q, rxrdy_q;
    logic          div64_q, fe_q;
    logic [DW-1:0] rxbuf_q;

    logic          tick, tx_busy, tx_done;
    logic          rx_valid, rx_ninth, rx_ferr;
    logic [DW-1:0] rx_word;
    logic          wr_data, wr_ctrl, wr_aux;

    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_aux  = bus_wr && (bus_addr == ADDR_AUX);

    sio_tick_sel #(.OVS(OVS)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_ext(tick16_i),
        .fixed_en(mode_is_fixed(mode_q)), .div64(div64_q), .tick(tick)
    );

    sio_tx #(.DW(DW), .OVS(OVS)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(wr_data),
        .data(bus_wdata), .ninth_en(mode_has_ninth(mode_q)), .ninth(tx9_q),
        .stop2(stop2_q), .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    sio_rx #(.DW(DW), .OVS(OVS)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .enable(rxen_q),
        .ninth_en(mode_has_ninth(mode_q)), .valid_o(rx_valid),
        .word_o(rx_word), .ninth_o(rx_ninth), .ferr_o(rx_ferr)
    );

    // Control register: configuration fields and sticky event flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {mode_q, stop2_q, rxen_q, tx9_q} <= '0;
            {rx9_q, txdone_q, rxrdy_q}       <= '0;
        end else begin
            if (wr_ctrl) begin
                mode_q   <= bus_wdata[7:6];
                stop2_q  <= bus_wdata[5];
                rxen_q   <= bus_wdata[4];
                tx9_q    <= bus_wdata[3];
                txdone_q <= txdone_q & bus_wdata[1];
                rxrdy_q  <= rxrdy_q & bus_wdata[0];
            end
            if (tx_done)  txdone_q <= 1'b1;
            if (rx_valid) begin
                rxrdy_q <= 1'b1;
                rx9_q   <= rx_ninth;
            end
        end
    end

    // Auxiliary register: fixed-rate divisor select and framing-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div64_q <= 1'b0;
            fe_q    <= 1'b0;
        end else begin
            if (wr_aux) begin
                div64_q <= bus_wdata[0];
                fe_q    <= fe_q & bus_wdata[1];
            end
            if (rx_valid && rx_ferr) fe_q <= 1'b1;
        end
    end

    // Receive buffer, loaded only by the receiver.
    always_ff @(posedge clk) begin
        if (!rst_n)        rxbuf_q <= '0;
        else if (rx_valid) rxbuf_q <= rx_word;
    end

    // Read multiplexer over the three addresses.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_DATA: bus_rdata = rxbuf_q;
            ADDR_CTRL: bus_rdata[7:0] = {mode_q, stop2_q, rxen_q, tx9_q,
                                         rx9_q, txdone_q, rxrdy_q};
            ADDR_AUX:  bus_rdata[1:0] = {fe_q, div64_q};
            default:   bus_rdata = '0;
        endcase
    end

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (txdone_q && !wr_ctrl) |=> txdone_q);
    a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rxrdy_q && !wr_ctrl) |=> rxrdy_q);
    a_r4_write_keeps_rxbuf: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !rx_valid) |=> $stable(rxbuf_q));
    a_r9_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_q && !wr_aux) |=> fe_q);

endmodule

// File: tb/sio_port_bench.sv
module sio_port_bench;
    localparam int TICKP = 4;
    localparam int VBIT  = 16 * TICKP;

    logic       clk = 0, rst_n = 0, tick16 = 0, tick_en = 1;
    logic       wr = 0, rxd = 1;
    logic [1:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    wire        txd;
    int         tcnt = 0;
    int         n_chk = 0, n_fail = 0;
    logic [7:0] last_rx = 0;

    sio_port u_sio_port (
        .clk(clk), .rst_n(rst_n), .tick16_i(tick16), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .rxd(rxd), .txd(txd)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tcnt   <= (tcnt == TICKP - 1) ? 0 : tcnt + 1;
        tick16 <= tick_en && (tcnt == TICKP - 1);
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1;
        @(negedge clk); wr = 0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    function automatic logic [7:0] cfg_word(input logic [1:0] m, input logic s2,
                                            input logic en, input logic t9);
        return {m, s2, en, t9, 3'b000};
    endfunction

    function automatic int bit_clocks(input logic [1:0] m, input logic d64);
        if (m == 2'b10) return d64 ? 64 : 32;
        return VBIT;
    endfunction

    // Send one frame and check the line and the done flag against the frame rules.
    task automatic tx_check(input logic [7:0] d, input logic [1:0] m, input logic t9,
                            input logic s2, input int bc, input logic idle_after);
        logic [7:0] r;
        int waited = 0;
        bus_write(0, d);
        while (txd !== 1'b0 && waited < 200) begin @(negedge clk); waited++; end
        repeat (bc / 2) @(negedge clk);
        chk(txd == 1'b0, "R1 start bit", txd, 0);
        for (int i = 0; i < 8; i++) begin
            repeat (bc) @(negedge clk);
            chk(txd == d[i], "R1 data bit lsb first", txd, d[i]);
        end
        if (m[1]) begin
            repeat (bc) @(negedge clk);
            chk(txd == t9, "R2 ninth bit", txd, t9);
        end
        repeat (bc) @(negedge clk);
        chk(txd == 1'b1, "R1 stop bit", txd, 1);
        if (s2) begin
            repeat (bc) @(negedge clk);
            chk(txd == 1'b1, "R5 second stop bit", txd, 1);
        end
        bus_read(1, r);
        chk(r[1] == 1'b0, "R5 done not before last stop ends", r[1], 0);
        repeat (bc / 2 + 4) @(negedge clk);
        bus_read(1, r);
        chk(r[1] == 1'b1, "R8 done set at frame end", r[1], 1);
        if (idle_after) begin
            int lows = 0;
            for (int k = 0; k < 2 * bc; k++) begin
                @(negedge clk);
                if (txd == 1'b0) lows++;
            end
            chk(lows == 0, "R10 no frame from write while busy", lows, 0);
        end
    endtask

    // Drive one frame onto the receive line.
    task automatic rx_send(input logic [7:0] d, input logic has9, input logic n9,
                           input logic stopv, input int bc);
        @(negedge clk); rxd = 0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (bc) @(negedge clk); end
        if (has9) begin rxd = n9; repeat (bc) @(negedge clk); end
        rxd = stopv; repeat (bc) @(negedge clk);
        rxd = 1; repeat (bc) @(negedge clk);
    endtask

    // Check what the receiver delivered.
    task automatic rx_expect(input logic [7:0] d, input logic exp9, input logic expfe);
        logic [7:0] r;
        bus_read(1, r);
        chk(r[0] == 1'b1, "R3 ready flag", r[0], 1);
        chk(r[2] == exp9, "R3 received ninth bit", r[2], exp9);
        bus_read(0, r);
        chk(r == d, "R3 received byte", r, d);
        bus_read(2, r);
        chk(r[1] == expfe, "R9 framing error flag", r[1], expfe);
        last_rx = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] r, d, d2;
        logic [1:0] m;
        logic s2, t9, d64, sv;
        int bc;
        void'($urandom(32'h5eed_0017));
        repeat (5) @(negedge clk);
        rst_n = 1;

        // Reset state
        chk(txd == 1'b1, "R1 idle line after reset", txd, 1);
        bus_read(1, r); chk(r == 8'h00, "R8 control after reset", r, 0);
        bus_read(2, r); chk(r == 8'h00, "R9 aux after reset", r, 0);
        bus_read(0, r); chk(r == 8'h00, "R4 data after reset", r, 0);

        // Random full-duplex frames in every mode
        for (int it = 0; it < 16; it++) begin
            m = 2'($urandom_range(0, 3)); d = 8'($urandom); d2 = 8'($urandom);
            s2 = 1'($urandom); t9 = 1'($urandom); d64 = 1'($urandom);
            sv = 1'($urandom);
            bc = bit_clocks(m, d64);
            bus_write(2, {7'b0, d64});
            bus_write(1, cfg_word(m, s2, 1'b1, t9));
            fork
                tx_check(d, m, t9, s2, bc, 1'b0);
                rx_send(d2, m[1], sv, 1'b1, bc);
            join
            rx_expect(d2, m[1] ? sv : 1'b1, 1'b0);   // R11 both directions together
        end

        // R4: a data write does not change what a data read returns
        bus_write(1, cfg_word(2'b01, 1'b0, 1'b1, 1'b0));
        tx_check(8'hA5, 2'b01, 1'b0, 1'b0, VBIT, 1'b0);
        bus_read(0, r); chk(r == last_rx, "R4 read after write keeps rx byte", r, last_rx);

        // R8: flags clear by writing 0 and keep on writing 1
        rx_send(8'h3C, 1'b0, 1'b0, 1'b1, VBIT);
        rx_expect(8'h3C, 1'b1, 1'b0);
        bus_write(1, cfg_word(2'b01, 1'b0, 1'b1, 1'b0) | 8'h02);
        bus_read(1, r); chk(r[1:0] == 2'b10, "R8 selective flag clear", r[1:0], 2);
        bus_write(1, cfg_word(2'b01, 1'b0, 1'b1, 1'b0));
        bus_read(1, r); chk(r[1:0] == 2'b00, "R8 both flags cleared", r[1:0], 0);

        // R7: short low pulse rejected
        rxd = 0; repeat (VBIT / 4) @(negedge clk); rxd = 1;
        repeat (2 * VBIT) @(negedge clk);
        bus_read(1, r); chk(r[0] == 1'b0, "R7 glitch gives no ready", r[0], 0);
        bus_read(0, r); chk(r == last_rx, "R7 glitch keeps data", r, last_rx);

        // R12: receiver disabled
        bus_write(1, cfg_word(2'b01, 1'b0, 1'b0, 1'b0));
        rx_send(8'hC3, 1'b0, 1'b0, 1'b1, VBIT);
        bus_read(1, r); chk(r[0] == 1'b0, "R12 disabled no ready", r[0], 0);
        bus_read(0, r); chk(r == last_rx, "R12 disabled keeps data", r, last_rx);

        // R9: low stop bit, byte still delivered, then a good frame follows
        bus_write(1, cfg_word(2'b01, 1'b0, 1'b1, 1'b0));
        rx_send(8'h96, 1'b0, 1'b0, 1'b0, VBIT);
        rx_expect(8'h96, 1'b0, 1'b1);
        bus_write(1, cfg_word(2'b01, 1'b0, 1'b1, 1'b0));
        rx_send(8'h69, 1'b0, 1'b0, 1'b1, VBIT);
        rx_expect(8'h69, 1'b1, 1'b1);
        bus_write(2, 8'h00);
        bus_read(2, r); chk(r[1] == 1'b0, "R9 error flag cleared by 0", r[1], 0);

        // R6: fixed rate with the tick input silenced, both divisors
        tick_en = 0;
        bus_write(2, 8'h00);
        bus_write(1, cfg_word(2'b10, 1'b0, 1'b1, 1'b1));
        tx_check(8'h81, 2'b10, 1'b1, 1'b0, 32, 1'b0);
        rx_send(8'h5B, 1'b1, 1'b0, 1'b1, 32);
        rx_expect(8'h5B, 1'b0, 1'b0);
        bus_write(2, 8'h01);
        bus_write(1, cfg_word(2'b10, 1'b1, 1'b1, 1'b0));
        tx_check(8'h7E, 2'b10, 1'b0, 1'b1, 64, 1'b0);
        tick_en = 1;

        // R10: a write during a frame is ignored
        bus_write(2, 8'h00);
        bus_write(1, cfg_word(2'b11, 1'b0, 1'b1, 1'b1));
        fork
            tx_check(8'h4D, 2'b11, 1'b1, 1'b0, VBIT, 1'b1);
            begin repeat (3 * VBIT) @(negedge clk); bus_write(0, 8'hB2); end
        join

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule